// File: doc/BRIEF.md
# Addend-Compensated Nanosecond Time Counter

This block keeps the time of day for a precision time protocol clock. Four reference strobes come into one clock domain. A clock-select field picks one of them as the timer reference. On each selected strobe, a programmable 32-bit addend is added into a 32-bit phase accumulator. The carry out of that sum is the nominal tick. Each tick advances a 64-bit nanosecond counter by a programmed period. Software trims the clock rate by changing the addend, in steps of one part in 2^32 of the reference rate. The reference itself does not change. The addend should be ceil(2^32 / R), where R is the reference rate over the nominal rate and R > 1. So at most one tick can occur per reference strobe.

A plain register port sets the control bits, addend, period, prescaler and a staged time value. The same port reads back these settings and the live time. A prescaler counts nominal ticks and emits a one-cycle output pulse on every N-th tick. Downstream pulse generators use this pulse.

Top module: `ptp_time_counter`

## Requirements
- R1: After synchronous reset, the time is 0, `tick_out` is low, and all registers read 0. This leaves the timer disabled with clock-select 0.
- R2: On a clock where the selected strobe is high, the timer is enabled and no load is pending, `addend` is added into the 32-bit accumulator. If that sum carries out of bit 31, the time grows by `period`. If it does not carry, the time holds. The new time is visible after that same edge.
- R3: Control register (address 0) bits [2:1] select which `ref_pulse` line is the reference: code 0 selects line 0, 1 line 1, 2 line 2, 3 line 3. Strobes on the other three lines do not change the time, the accumulator or `tick_out`.
- R4: While control bit 0 (enable) is 0, both the time and the accumulator hold their values.
- R5: A write to address 4 stages the low 32 bits of a new time. A write to address 5 stages the high 32 bits and arms a load. At the next selected strobe, the time takes the staged value whether or not the timer is enabled, and the increment is skipped on that edge. The accumulator still advances (if enabled), so its fractional residue is kept.
- R6: A write of the addend (address 1) or the period (address 2, low 8 bits) is taken whole in one clock and applies from the next clock on.
- R7: Address 3 holds the prescale count N in 16 bits, where 0 acts as 1. `tick_out` is a one-clock pulse, registered on the same edge as the counter, on every N-th carry.
- R8: `rd_data` shows the register at `addr` without delay. Address 0 gives {enable at bit 0, select at bits 2:1}, 1 the addend, 2 the period, 3 the prescale, 4 time bits 31:0, 5 time bits 63:32, and 6–7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 4 | One-clock reference strobes, one per selectable source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| time_ns | output | 64 | Live nanosecond time |
| tick_out | output | 1 | Prescaled nominal tick pulse |

## Verification
Assertions check the following on every cycle:
- the time holds when the selected strobe is absent or the timer is disabled;
- a strobe with no pending load moves the time by either zero or one period;
- a pending load puts the staged value in exactly;
- an output tick appears only after a selected strobe.

Some behaviours only the bench's scenarios can show. One is the exact carry pattern that different addends produce. Others are the accumulator residue kept across a load, the prescaler count, and source selection among active strobe lines. The bench's cycle-accurate reference model and its directed checks cover these.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int PER_W  = 8,
  parameter int PRSC_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  ref_pulse,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [63:0] time_ns,
  output logic        tick_out
);
  localparam int ACC_W = 32;

  logic              en;
  logic [1:0]        sel;
  logic [ACC_W-1:0]  addend, acc;
  logic [PER_W-1:0]  period;
  logic [PRSC_W-1:0] prsc, pcnt;
  logic [31:0]       stage_lo;
  logic [63:0]       stage, time_q;
  logic              pend, tick_q;

  wire               ref_sel = ref_pulse[sel];
  wire [ACC_W:0]     sum     = {1'b0, acc} + {1'b0, addend};
  wire               carry   = sum[ACC_W];
  wire [PRSC_W-1:0]  plim    = (prsc == '0) ? PRSC_W'(1) : prsc;
  wire               pwrap   = (pcnt >= plim - PRSC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; sel <= '0; addend <= '0; period <= '0; prsc <= '0;
      acc <= '0; pcnt <= '0; stage_lo <= '0; stage <= '0; time_q <= '0;
      pend <= 1'b0; tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (ref_sel) begin
        if (pend) begin
          time_q <= stage;
          pend   <= 1'b0;
        end else if (en && carry) begin
          time_q <= time_q + 64'(period);
        end
        if (en) begin
          acc <= sum[ACC_W-1:0];
          if (carry) begin
            pcnt   <= pwrap ? '0 : pcnt + PRSC_W'(1);
            tick_q <= pwrap;
          end
        end
      end
      if (wr_en) begin
        case (addr)
          3'd0: {sel, en} <= wr_data[2:0];
          3'd1: addend    <= wr_data;
          3'd2: period    <= wr_data[PER_W-1:0];
          3'd3: prsc      <= wr_data[PRSC_W-1:0];
          3'd4: stage_lo  <= wr_data;
          3'd5: begin stage <= {wr_data, stage_lo}; pend <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = 32'({sel, en});
      3'd1:    rd_data = addend;
      3'd2:    rd_data = 32'(period);
      3'd3:    rd_data = 32'(prsc);
      3'd4:    rd_data = time_q[31:0];
      3'd5:    rd_data = time_q[63:32];
      default: rd_data = '0;
    endcase
  end

  assign time_ns  = time_q;
  assign tick_out = tick_q;

  p_no_strobe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ref_sel |=> $stable(time_q));

  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !pend) |=> ($stable(time_q) && $stable(acc)));

  p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_sel && en && !pend) |=>
      (time_q == $past(time_q) || time_q == $past(time_q) + 64'($past(period))));

  p_load_exact_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_sel && pend) |=> (time_q == $past(stage)));

  p_tick_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    tick_out |-> $past(ref_sel));
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ref_pulse = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] time_ns;
  logic        tick_out;

  int checks = 0;
  int fails  = 0;
  logic [3:0] pmask = 4'b0000;

  always #10 clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .time_ns(time_ns), .tick_out(tick_out)
  );

  // behavioural reference model
  longint unsigned m_time, m_stage, m_acc, m_add;
  int unsigned m_lo, m_per, m_prsc, m_cnt;
  bit m_en, m_pend, m_tick;
  int m_sel;

  always @(posedge clk) begin
    if (rst) begin
      m_time = 0; m_stage = 0; m_acc = 0; m_add = 0; m_lo = 0; m_per = 0;
      m_prsc = 0; m_cnt = 0; m_en = 0; m_pend = 0; m_tick = 0; m_sel = 0;
    end else begin
      bit hit;
      bit cy;
      longint unsigned s;
      hit = ref_pulse[m_sel];
      m_tick = 0;
      if (hit) begin
        s  = m_acc + m_add;
        cy = (s >= 64'h1_0000_0000);
        if (m_pend) begin m_time = m_stage; m_pend = 0; end
        else if (m_en && cy) m_time = m_time + m_per;
        if (m_en) begin
          m_acc = s % 64'h1_0000_0000;
          if (cy) begin
            m_cnt = m_cnt + 1;
            if (m_cnt >= ((m_prsc == 0) ? 1 : m_prsc)) begin m_cnt = 0; m_tick = 1; end
          end
        end
      end
      if (wr_en) begin
        case (addr)
          0: begin m_en = wr_data[0]; m_sel = int'(wr_data[2:1]); end
          1: m_add = wr_data;
          2: m_per = wr_data & 32'hFF;
          3: m_prsc = wr_data & 32'hFFFF;
          4: m_lo = wr_data;
          5: begin m_stage = {wr_data, m_lo}; m_pend = 1; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      0: return 32'({m_sel[1:0], m_en});
      1: return m_add[31:0];
      2: return m_per;
      3: return m_prsc;
      4: return m_time[31:0];
      5: return m_time[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      chk("R2 time vs model", time_ns, m_time);
      chk("R7 tick vs model", 64'(tick_out), 64'(m_tick));
      chk("R8 rd_data vs model", 64'(rd_data), 64'(m_read(addr)));
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_pulse = 4'($urandom) & pmask;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    ref_pulse = 4'($urandom) & pmask;
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; ref_pulse = '0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 time after reset", time_ns, 64'h0);
    chk("R1 tick after reset", 64'(tick_out), 64'h0);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 register reads zero", 64'(rd_data), 64'h0);
    end

    // R2/R6: addend 2^31 -> carry every second strobe, period 10
    wr(3'd1, 32'h8000_0000);
    wr(3'd2, 32'h0000_010A);   // upper bits ignored, period 10
    wr(3'd3, 32'd3);
    wr(3'd0, 32'd3);           // sel 1, enable
    addr = 3'd2; #1;
    chk("R6 period low bits only", 64'(rd_data), 64'd10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ref_pulse = 4'b0010;
    end
    @(negedge clk); ref_pulse = '0;
    chk("R2 eight strobes give four ticks", time_ns, 64'd40);

    // R3: strobes on unselected lines ignored
    held = time_ns;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ref_pulse = 4'b1101;
    end
    @(negedge clk); ref_pulse = '0;
    chk("R3 unselected strobes ignored", time_ns, held);

    pmask = 4'b1111;
    run(60);

    // R4: disabled holds
    wr(3'd0, 32'd2);
    held = time_ns;
    run(20);
    chk("R4 disabled time holds", time_ns, held);

    // R5: staged load while disabled, near 32-bit boundary
    pmask = 4'b0000;
    wr(3'd4, 32'hFFFF_FFF0);
    wr(3'd5, 32'h0000_0001);
    chk("R5 no load before strobe", time_ns, held);
    @(negedge clk); ref_pulse = 4'b0010;
    @(negedge clk); ref_pulse = '0;
    chk("R5 load applied on strobe", time_ns, 64'h1_FFFF_FFF0);

    // R6: new addend, cross carry into high word
    wr(3'd1, 32'h6000_0000);
    wr(3'd0, 32'd3);
    pmask = 4'b1111;
    run(80);
    addr = 3'd5; #1;
    chk("R8 high word read", 64'(rd_data), 64'(time_ns[63:32]));

    // R5 with enable on: load during running, residue kept
    wr(3'd4, 32'h0000_1000);
    wr(3'd5, 32'h0000_0000);
    run(40);

    // R3: select line 3, R7 prescale 0 -> every carry
    wr(3'd0, 32'd7);
    wr(3'd3, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    run(50);
    addr = 3'd0; #1;
    chk("R8 control readback", 64'(rd_data), 64'd7);

    // R7: prescale 5 on a steady strobe stream
    wr(3'd1, 32'h8000_0000);
    wr(3'd3, 32'd5);
    pmask = 4'b1000;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ref_pulse = 4'b1000;
    end
    ref_pulse = '0;

    // R8 readback of every address
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a); #1;
      chk("R8 address readback", 64'(rd_data), 64'(m_read(3'(a))));
    end
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule